// File: doc/BRIEF.md
# Host-to-Local Address Translation Window

This block maps a 32-bit host address onto a 24-bit on-chip RAM address through one programmable window. The host hands over a request with a valid/ready handshake. The block then decides whether the address lies inside the window. The window is set by a host base register and a size code. If the address is inside, the block removes the window offset from the base and places it above a programmable local start address. It then issues one RAM access strobe with the translated address. Any address outside the window gets an address exception pulse instead, and no RAM access takes place. The same happens for any address whose translation would leave the legal RAM region `FFD100`..`FFEFFF`.

Four configuration registers are written through a single-cycle write port. The control path is a two-state machine. State `ST_IDLE` holds `req_ready` high. On transition `ACCEPT` (valid and ready both high) it moves to `ST_RESP`, which lasts exactly one cycle. In that cycle the response is driven and `req_ready` is low. The unconditional transition `DONE` then returns to `ST_IDLE`.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset the window is disabled (enable = 0), `req_ready` is 1, `ram_strobe` and `addr_exc` are 0, and every accepted request answers with an exception.
- R2: `req_ready` is 1 in `ST_IDLE`. A request accepted at a clock edge (valid and ready high) is answered in the following cycle, and in that cycle `req_ready` is 0.
- R3: Each accepted request produces exactly one one-cycle pulse: either `ram_strobe` or `addr_exc`, never both. No pulse appears without an accepted request.
- R4: On a strobe, `ram_addr` = {8'hFF, page, 8'h00} + (host address − aligned base), where page is the local start register.
- R5: The size code (wdata[2:0]) selects a window of 256 << min(code,5) bytes, so codes 5..7 all mean 8 kbytes. An address is inside when it agrees with the base on all bits above the window size. Base bits below the window size are ignored.
- R6: A host address outside the window produces `addr_exc` and no strobe.
- R7: An in-window address whose translated value is above `FFEFFF` or below `FFD100` produces `addr_exc` and no strobe.
- R8: A configuration write in the same cycle as a request's acceptance does not affect that request. It affects only requests accepted later.
- R9: Register select `cfg_sel`: 0 = host base (wdata[31:0]), 1 = size code (wdata[2:0]), 2 = local start page (wdata[7:0]), 3 = enable (wdata[0]).
- R10: With base `10000000`, page `D1` and size code 5, host address `10000100` translates to `FFD200`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Host address |
| ram_strobe | output | 1 | One-cycle local RAM access strobe |
| ram_addr | output | 24 | Translated local address, valid with strobe |
| addr_exc | output | 1 | One-cycle address exception pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit host address, a 24-bit local address, and window sizes from 256 bytes to 8 kbytes. This range brings both ends of the window within reach. With the largest window and the lowest legal page, the top of the window crosses `FFEFFF`. With a low page, the translated address falls below `FFD100`. The smallest window shows that base bits below the size are ignored. Codes above the largest legal value exercise the clamp.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xl_state_t;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_SIZE  = 2'd1;
    localparam logic [1:0] SEL_PAGE  = 2'd2;
    localparam logic [1:0] SEL_EN    = 2'd3;
endpackage

// File: rtl/xlate_cfg.sv
module xlate_cfg
    import xlate_pkg::*;
#(
    parameter int HAW    = 32,
    parameter int CODE_W = 3,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [HAW-1:0]    wdata,
    output logic [HAW-1:0]    base,
    output logic [CODE_W-1:0] code,
    output logic [PAGE_W-1:0] page,
    output logic              en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
            code <= '0;
            page <= '0;
            en   <= 1'b0;
        end else if (we) begin
            unique case (sel)
                SEL_BASE: base <= wdata;
                SEL_SIZE: code <= wdata[CODE_W-1:0];
                SEL_PAGE: page <= wdata[PAGE_W-1:0];
                SEL_EN:   en   <= wdata[0];
            endcase
        end
    end
endmodule

// File: rtl/xlate_map.sv
module xlate_map #(
    parameter int              HAW      = 32,
    parameter int              LAW      = 24,
    parameter int              CODE_W   = 3,
    parameter int              PAGE_W   = 8,
    parameter int              PAGE_LSB = 8,
    parameter int              MIN_LOG  = 8,
    parameter int              MAX_LOG  = 13,
    parameter logic [LAW-1:0]  RAM_LO   = 24'hFFD100,
    parameter logic [LAW-1:0]  RAM_HI   = 24'hFFEFFF
) (
    input  logic [HAW-1:0]    addr,
    input  logic [HAW-1:0]    base,
    input  logic [CODE_W-1:0] code,
    input  logic [PAGE_W-1:0] page,
    input  logic              en,
    output logic              hit,
    output logic [LAW-1:0]    loc
);
    localparam int          MAX_CODE = MAX_LOG - MIN_LOG;
    localparam int          TOP_W    = LAW - PAGE_W - PAGE_LSB;
    localparam logic [HAW-1:0] ONE   = {{(HAW-1){1'b0}}, 1'b1};

    logic [CODE_W-1:0] eff_code;
    logic [HAW-1:0]    mask;
    logic [LAW-1:0]    lbase;
    logic [LAW:0]      sum;
    logic              in_win;
    logic              in_ram;

    always_comb begin
        eff_code = (int'(code) > MAX_CODE) ? CODE_W'(MAX_CODE) : code;
        mask     = (ONE << (MIN_LOG + int'(eff_code))) - ONE;
        in_win   = en && ((addr & ~mask) == (base & ~mask));
        lbase    = {{TOP_W{1'b1}}, page, {PAGE_LSB{1'b0}}};
        sum      = {1'b0, lbase} + {1'b0, addr[LAW-1:0] & mask[LAW-1:0]};
        in_ram   = !sum[LAW] && (sum[LAW-1:0] <= RAM_HI) && (sum[LAW-1:0] >= RAM_LO);
        hit      = in_win && in_ram;
        loc      = sum[LAW-1:0];
    end
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import xlate_pkg::*;
#(
    parameter int              HAW      = 32,
    parameter int              LAW      = 24,
    parameter int              MIN_LOG  = 8,
    parameter int              MAX_LOG  = 13,
    parameter logic [LAW-1:0]  RAM_LO   = 24'hFFD100,
    parameter logic [LAW-1:0]  RAM_HI   = 24'hFFEFFF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [HAW-1:0] cfg_wdata,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [HAW-1:0] req_addr,
    output logic           ram_strobe,
    output logic [LAW-1:0] ram_addr,
    output logic           addr_exc
);
    localparam int CODE_W   = 3;
    localparam int PAGE_W   = 8;
    localparam int PAGE_LSB = 8;

    logic [HAW-1:0]    base;
    logic [CODE_W-1:0] code;
    logic [PAGE_W-1:0] page;
    logic              en;
    logic              hit;
    logic [LAW-1:0]    loc;

    xl_state_t      state, state_nx;
    logic           hit_q;
    logic [LAW-1:0] addr_q;
    logic           accept;

    xlate_cfg #(.HAW(HAW), .CODE_W(CODE_W), .PAGE_W(PAGE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .base(base), .code(code), .page(page), .en(en)
    );

    xlate_map #(
        .HAW(HAW), .LAW(LAW), .CODE_W(CODE_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB),
        .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)
    ) u_map (
        .addr(req_addr), .base(base), .code(code), .page(page), .en(en),
        .hit(hit), .loc(loc)
    );

    assign accept = req_valid && req_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_RESP;   // ACCEPT
            ST_RESP: state_nx = ST_IDLE;               // DONE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hit_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                hit_q  <= hit;
                addr_q <= loc;
            end
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        ram_strobe = 1'b0;
        addr_exc   = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: begin
                ram_strobe = hit_q;
                addr_exc   = !hit_q;
            end
        endcase
        ram_addr = addr_q;
    end

    // R2
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (ram_strobe || addr_exc) && !req_ready);

    // R3
    no_orphan_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_strobe || addr_exc) |-> $past(req_valid && req_ready));

    // R3
    strobe_exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_strobe && addr_exc));

    // R7
    legal_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_strobe |-> (ram_addr >= RAM_LO) && (ram_addr <= RAM_HI));

    // R1
    disabled_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !en) |=> addr_exc);
endmodule

// File: tb/addr_window_xlate_test.sv
module addr_window_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        ram_strobe;
    logic [23:0] ram_addr;
    logic        addr_exc;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";
    bit    done    = 0;

    always #5 clk = ~clk;

    addr_window_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .ram_strobe(ram_strobe), .ram_addr(ram_addr), .addr_exc(addr_exc)
    );

    // behavioural reference model
    longint m_base = 0, m_code = 0, m_page = 0;
    bit     m_en = 0;
    bit     m_busy = 0, m_str = 0, m_exc = 0;
    longint m_addr = 0;

    function automatic void predict(input longint a, output bit ok, output longint l);
        longint sz, c;
        c  = (m_code > 5) ? 5 : m_code;
        sz = 256 << c;
        l  = 64'hFF0000 + m_page * 256 + (a % sz);
        ok = m_en && ((a / sz) == (m_base / sz)) && l >= 64'hFFD100 && l <= 64'hFFEFFF;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_base <= 0; m_code <= 0; m_page <= 0; m_en <= 0;
            m_busy <= 0; m_str <= 0; m_exc <= 0; m_addr <= 0;
        end else begin
            bit ok; longint l; bit acc;
            acc = req_valid && !m_busy;
            predict(longint'(req_addr), ok, l);
            m_busy <= acc;
            m_str  <= acc && ok;
            m_exc  <= acc && !ok;
            if (acc) m_addr <= l;
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_base <= longint'(cfg_wdata);
                    2'd1: m_code <= longint'(cfg_wdata[2:0]);
                    2'd2: m_page <= longint'(cfg_wdata[7:0]);
                    default: m_en <= cfg_wdata[0];
                endcase
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, req_ready, !m_busy, "req_ready (R2)");
            check(phase, ram_strobe, m_str, "ram_strobe (R3)");
            check(phase, addr_exc, m_exc, "addr_exc (R3)");
            if (m_str) check(phase, ram_addr, m_addr, "ram_addr (R4)");
        end
    end

    task automatic cfg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // issue one request; returns with outputs showing the response
    task automatic req(input logic [31:0] a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_resp(input string r, input bit s, input longint la);
        check(r, ram_strobe, s, "strobe");
        check(r, addr_exc, !s, "exception");
        if (s) check(r, ram_addr, la, "address");
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                done = 1;
            end
            begin
                repeat (3) @(negedge clk);
                // R1: reset state
                check("R1", req_ready, 1, "ready after reset");
                check("R1", ram_strobe, 0, "strobe after reset");
                check("R1", addr_exc, 0, "exc after reset");
                rst_n = 1'b1;
                phase = "R1";
                req(32'h1000_0100);
                expect_resp("R1", 0, 0);

                // R9, R10: example mapping
                phase = "R10";
                cfg(2'd0, 32'h1000_0000); cfg(2'd1, 32'd5); cfg(2'd2, 32'hD1); cfg(2'd3, 32'd1);
                req(32'h1000_0100);
                expect_resp("R10", 1, 64'hFFD200);
                check("R2", req_ready, 0, "ready low in response cycle");

                // R7: top of legal region and above
                phase = "R7";
                req(32'h1000_1EFF); expect_resp("R7", 1, 64'hFFEFFF);
                req(32'h1000_1F00); expect_resp("R7", 0, 0);
                cfg(2'd2, 32'h00);
                req(32'h1000_0010); expect_resp("R7", 0, 0);
                cfg(2'd2, 32'hD1);

                // R6: outside window
                phase = "R6";
                req(32'h1000_2000); expect_resp("R6", 0, 0);
                req(32'h0FFF_FFFF); expect_resp("R6", 0, 0);

                // R5: small window, base low bits ignored, code clamp
                phase = "R5";
                cfg(2'd1, 32'd0); cfg(2'd0, 32'h2000_0080); cfg(2'd2, 32'hE0);
                req(32'h2000_00FF); expect_resp("R5", 1, 64'hFFE0FF);
                req(32'h2000_0100); expect_resp("R5", 0, 0);
                cfg(2'd1, 32'd7); cfg(2'd2, 32'hD1); cfg(2'd0, 32'h2000_0000);
                req(32'h2000_1000); expect_resp("R5", 1, 64'hFFE100);

                // R8: write in acceptance cycle does not affect that request
                phase = "R8";
                @(negedge clk);
                req_valid = 1'b1; req_addr = 32'h2000_0004;
                cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'd0;
                @(negedge clk);
                req_valid = 1'b0; cfg_we = 1'b0;
                expect_resp("R8", 1, 64'hFFD104);
                req(32'h2000_0004); expect_resp("R8", 0, 0);
                cfg(2'd3, 32'd1);

                // R2: valid held high, back-to-back
                phase = "R2";
                @(negedge clk);
                req_valid = 1'b1; req_addr = 32'h2000_0200;
                repeat (6) @(negedge clk);
                req_valid = 1'b0;

                // R4: mixed traffic with changing configuration
                phase = "R4";
                for (int i = 0; i < 400; i++) begin
                    if (i % 25 == 0) begin
                        cfg(2'd0, $urandom() & 32'hFFFF_E000 | 32'h4000_0000);
                        cfg(2'd1, $urandom_range(0, 7));
                        cfg(2'd2, $urandom_range(32'hC0, 32'hFF));
                    end
                    @(negedge clk);
                    req_valid = ($urandom_range(0, 3) != 0);
                    req_addr  = ($urandom_range(0, 3) == 0) ? $urandom()
                              : (32'h4000_0000 | ($urandom() & 32'hBFFF_FFFF & 32'h4000_1FFF));
                end
                @(negedge clk);
                req_valid = 1'b0;
                repeat (3) @(negedge clk);
                done = 1;
            end
        join_any
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule